// File: doc/BRIEF.md
# Isolation Link Edge Pulse Encoder

This block is the transmit half of a digital isolation channel. It watches one logic input and converts its level changes into short pulses on two separate lines toward a barrier-coupling element: a set pulse marks a rise and a clear pulse marks a fall. The receiving side keeps a bistable latch that these pulses set or clear, so the far output follows the input.

If the input stays still for a configurable idle interval, the block re-sends its present level as a refresh pulse: a set pulse while the input is high, a clear pulse while it is low. Refresh pulses repeat at that interval until the input changes, so a receiver that missed a pulse or has just powered up regains the correct level. A power-good input from an undervoltage monitor holds the whole block idle and cleared while the supply is low. Pulse width and idle interval are counted in clock cycles and set by parameters.

The input crosses into the clock domain through a two-stage synchronizer. The two pulse lines are never active together. A request that arrives while a pulse is still being driven waits in a one-entry slot and starts in the cycle after that pulse ends.

Top module: `iso_pulse_encoder`

## Requirements
- R1: Each 0-to-1 change of `din` produces exactly one pulse on `set_pulse`, held high for `PULSE_CYC` consecutive cycles.
- R2: Each 1-to-0 change of `din` produces exactly one pulse on `clr_pulse`, held high for `PULSE_CYC` consecutive cycles.
- R3: With the default two synchronizer stages, and no pulse in progress, the edge pulse is first visible after the third rising clock edge, counting the edge that first samples the new `din` value as the first.
- R4: When no edge request has occurred for `IDLE_CYC` cycles, a refresh pulse starts, on `set_pulse` if the synchronized level is 1 and on `clr_pulse` if it is 0. The refresh starts `IDLE_CYC` cycles after the start of the previous edge pulse's nominal slot.
- R5: While the level stays constant, refresh pulses continue with their nominal starts exactly `IDLE_CYC` cycles apart.
- R6: An edge request takes precedence over a refresh request that falls in the same cycle. Only the edge pulse is sent, and the next refresh is timed from that edge.
- R7: `set_pulse` and `clr_pulse` are never high in the same cycle.
- R8: A request that arrives while a pulse is still being driven is held. Its pulse starts in the cycle right after the current pulse's last cycle. Requests must be spaced so that no more than one request waits at a time.
- R9: While `pwr_ok` is 0, both pulse outputs are 0 from the next cycle on, any pulse in progress is cut, and `din` is ignored. All internal state returns to its reset value.
- R10: When `pwr_ok` rises, sampling starts at once. If `din` is already 1, a set pulse follows with the R3 latency. If `din` is 0, the first refresh (a clear pulse) starts `IDLE_CYC` cycles after the cycle in which `pwr_ok` was first seen high.
- R11: While `rst` is high, both pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply-good indication; 0 holds the block idle |
| din | input | 1 | Asynchronous logic input to be carried across the barrier |
| set_pulse | output | 1 | Pulse line that marks a rise or refreshes a high level |
| clr_pulse | output | 1 | Pulse line that marks a fall or refreshes a low level |

## Verification
The input is driven in several patterns. A long steady high and a long steady low show the refresh spacing and that the refresh kind follows the level. Rapid alternation spaced just over one pulse width checks edge latency and polarity without any queueing. An edge placed on the exact cycle a refresh is due separates edge precedence from a plain refresh. Edges placed inside a running refresh pulse expose the hold-and-follow timing of the waiting slot. Power is dropped in the middle of a pulse and then restored, with `din` both high and low, to tell the cut-off and the restart timing apart from normal refresh timing.

// File: rtl/iso_enc_pkg.sv
package iso_enc_pkg;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_SET  = 2'd1,
        PK_CLR  = 2'd2
    } pulse_kind_e;

    typedef struct packed {
        logic        valid;
        pulse_kind_e kind;
    } pulse_req_t;

    localparam pulse_req_t REQ_NONE = '{valid: 1'b0, kind: PK_NONE};

    function automatic pulse_kind_e level_to_kind(input logic lvl);
        return lvl ? PK_SET : PK_CLR;
    endfunction

endpackage

// File: rtl/iso_enc_sync.sv
module iso_enc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (clr) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/iso_enc_sched.sv
module iso_enc_sched
    import iso_enc_pkg::*;
#(
    parameter int IDLE_CYC = 100
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       lvl_in,
    output pulse_req_t req
);
    localparam int CW = (IDLE_CYC > 2) ? $clog2(IDLE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYC - 1);

    logic          lvl_q;
    logic [CW-1:0] idle_cnt;
    logic          edge_hit;
    logic          due;

    assign edge_hit = lvl_in != lvl_q;
    assign due      = idle_cnt == LAST;

    always_ff @(posedge clk) begin
        if (clr) begin
            lvl_q    <= 1'b0;
            idle_cnt <= '0;
        end else begin
            lvl_q <= lvl_in;
            if (edge_hit || due) idle_cnt <= '0;
            else                 idle_cnt <= idle_cnt + CW'(1);
        end
    end

    always_comb begin
        req = REQ_NONE;
        if (edge_hit) begin
            req.valid = 1'b1;
            req.kind  = level_to_kind(lvl_in);
        end else if (due) begin
            req.valid = 1'b1;
            req.kind  = level_to_kind(lvl_q);
        end
    end

    AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (clr)
        idle_cnt <= LAST); // R5
    AST_INTERVAL_RESTART: assert property (@(posedge clk) disable iff (clr)
        req.valid |=> idle_cnt == '0); // R6
endmodule

// File: rtl/iso_enc_pulse.sv
module iso_enc_pulse
    import iso_enc_pkg::*;
#(
    parameter int PULSE_CYC = 1
) (
    input  logic       clk,
    input  logic       clr,
    input  pulse_req_t req,
    output logic       set_o,
    output logic       clr_o
);
    localparam int LW = $clog2(PULSE_CYC + 1);
    localparam logic [LW-1:0] FULL = LW'(PULSE_CYC);
    localparam logic [LW-1:0] ONE  = LW'(1);

    pulse_kind_e cur_kind;
    logic [LW-1:0] left;
    pulse_req_t    pend;
    logic          busy;

    assign busy = left > ONE;

    always_ff @(posedge clk) begin
        if (clr) begin
            cur_kind <= PK_NONE;
            left     <= '0;
            pend     <= REQ_NONE;
        end else if (busy) begin
            left <= left - ONE;
            if (req.valid) pend <= req;
        end else if (pend.valid) begin
            cur_kind <= pend.kind;
            left     <= FULL;
            pend     <= req;
        end else if (req.valid) begin
            cur_kind <= req.kind;
            left     <= FULL;
        end else begin
            cur_kind <= PK_NONE;
            left     <= '0;
        end
    end

    assign set_o = (left != '0) && (cur_kind == PK_SET);
    assign clr_o = (left != '0) && (cur_kind == PK_CLR);

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (clr)
        !(set_o && clr_o)); // R7
    AST_NO_LOST_REQ: assert property (@(posedge clk) disable iff (clr)
        !(busy && pend.valid && req.valid)); // R8
    AST_PENDING_FOLLOWS: assert property (@(posedge clk) disable iff (clr)
        (!busy && pend.valid) |=> (left == FULL && cur_kind == $past(pend.kind))); // R8
    AST_FRESH_START: assert property (@(posedge clk) disable iff (clr)
        (!busy && !pend.valid && req.valid) |=> (left == FULL && cur_kind == $past(req.kind))); // R1
endmodule

// File: rtl/iso_pulse_encoder.sv
module iso_pulse_encoder
    import iso_enc_pkg::*;
#(
    parameter int PULSE_CYC   = 1,
    parameter int IDLE_CYC    = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic din,
    output logic set_pulse,
    output logic clr_pulse
);
    logic       hold;
    logic       lvl_sync;
    pulse_req_t req;

    assign hold = rst || !pwr_ok;

    iso_enc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .clr (hold),
        .d   (din),
        .q   (lvl_sync)
    );

    iso_enc_sched #(.IDLE_CYC(IDLE_CYC)) u_sched (
        .clk    (clk),
        .clr    (hold),
        .lvl_in (lvl_sync),
        .req    (req)
    );

    iso_enc_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk   (clk),
        .clr   (hold),
        .req   (req),
        .set_o (set_pulse),
        .clr_o (clr_pulse)
    );

    AST_DOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> (!set_pulse && !clr_pulse)); // R9
endmodule

// File: tb/sim_iso_pulse_encoder.sv
module sim_iso_pulse_encoder;
    localparam int P    = 3;
    localparam int IDLE = 20;

    typedef struct {
        int    kind;     // 1 = set line, 2 = clear line
        int    nominal;  // cycle the pulse would start with nothing ahead of it
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_ok = 1'b0;
    logic din = 1'b0;
    logic set_p, clr_p;

    iso_pulse_encoder #(.PULSE_CYC(P), .IDLE_CYC(IDLE), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .din(din),
        .set_pulse(set_p), .clr_pulse(clr_p)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    exp_t q[$];

    // driver model state
    int   last_t = 0;
    logic cur = 1'b0;
    bit   pwr_st = 1'b0;
    bit   after_pu = 1'b0;
    int   nref = 0;
    // monitor state
    bit   cut = 1'b0;
    int   prev_end = 0;
    int   run_k = 0;
    int   run_len = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int k, input int nom, input string tag);
        exp_t e;
        e.kind = k; e.nominal = nom; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input logic d, input string tag = "");
        int n;
        @(negedge clk); #2;
        n = cyc;
        if (pwr_st) begin
            while (last_t + IDLE <= n + 2) begin
                last_t = last_t + IDLE;
                push(cur ? 1 : 2, last_t, after_pu ? "R10" : (nref == 0 ? "R4" : "R5"));
                after_pu = 1'b0;
                nref++;
            end
            if (d !== cur) begin
                push(d ? 1 : 2, n + 3, (tag != "") ? tag : (d ? "R1/R3" : "R2/R3"));
                last_t = n + 3;
                cur = d;
                nref = 0;
                after_pu = 1'b0;
            end
        end
        din = d;
    endtask

    task automatic power_up();
        @(negedge clk); #2;
        pwr_ok = 1'b1; pwr_st = 1'b1; cut = 1'b0; prev_end = 0;
        cur = 1'b0; last_t = cyc; nref = 0; after_pu = 1'b1;
        if (din) begin
            push(1, cyc + 3, "R10");
            last_t = cyc + 3; cur = 1'b1; after_pu = 1'b0;
        end
    endtask

    task automatic power_down();
        @(negedge clk); #2;
        pwr_ok = 1'b0; pwr_st = 1'b0; cut = 1'b1;
        q.delete();
        @(negedge clk); #1;
        chk(!set_p, "R9 set line after power loss", set_p, 0);
        chk(!clr_p, "R9 clear line after power loss", clr_p, 0);
    endtask

    // monitor: pops expected pulses as they start
    always @(negedge clk) begin
        if (!rst) begin
            int ck;
            ck = set_p ? 1 : (clr_p ? 2 : 0);
            if (set_p && clr_p) chk(1'b0, "R7 both lines high", 1, 0);
            if (run_k != 0 && (ck != run_k || run_len == P)) begin
                if (!cut) chk(run_len == P, "R1/R2 pulse width", run_len, P);
                run_k = 0;
            end
            if (ck != 0 && run_k == 0) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9 unexpected pulse kind", ck, 0);
                end else begin
                    exp_t e;
                    int es;
                    e = q.pop_front();
                    es = (e.nominal > prev_end) ? e.nominal : prev_end;
                    chk(ck == e.kind, {e.tag, " pulse kind"}, ck, e.kind);
                    chk(cyc == es, {e.tag, " pulse start cycle"}, cyc, es);
                end
                prev_end = cyc + P;
                run_k = ck;
                run_len = 1;
            end else if (ck != 0) begin
                run_len++;
            end
        end
    end

    task automatic run_all();
        int target;
        repeat (3) @(negedge clk);
        #1;
        chk(!set_p && !clr_p, "R11 outputs in reset", {30'd0, set_p, clr_p}, 0);
        #1 rst = 1'b0;

        // power low: toggling input is ignored
        for (int i = 0; i < 10; i++) step(i[0]);
        step(1'b1);
        power_up();                              // R10 set pulse
        repeat (45) step(1'b1);                  // R4 / R5 set refreshes
        step(1'b0);                              // R2 fall
        repeat (45) step(1'b0);                  // clear refreshes

        // rapid alternation, no queueing
        for (int k = 0; k < 6; k++) begin
            step(1'b1);
            repeat (3) step(1'b1);
            step(1'b0);
            repeat (4) step(1'b0);
        end

        // R6: edge on the cycle a refresh is due
        target = last_t + IDLE;
        while (cyc + 4 < target) step(cur);
        step(~cur, "R6");
        repeat (25) step(cur);

        // R8: edges arriving inside a running refresh pulse
        target = last_t + IDLE + 1;
        while (cyc + 4 < target) step(cur);
        step(~cur, "R8");
        repeat (2) step(cur);
        step(~cur, "R8");
        repeat (30) step(cur);

        // R9: cut a refresh pulse in progress
        target = last_t + IDLE;
        while (cyc < target) step(cur);
        power_down();
        repeat (5) step(1'b1);
        step(1'b0);
        power_up();                              // R10 first clear refresh
        repeat (30) step(1'b0);
        step(1'b1);
        repeat (10) step(1'b1);

        foreach (q[i])
            if (q[i].nominal < cyc - 2 * P)
                chk(1'b0, {q[i].tag, " pulse missing"}, 0, q[i].nominal);
        power_down();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule